// File: doc/BRIEF.md
# DNA Token Stream Generator

This block takes a short DNA read one nucleotide per cycle over a valid/ready handshake. Each nucleotide is a 2-bit code. From these it produces every overlapping fixed-length token (k-mer) of the read. Each token leaves as the row index of a presence table that holds one row per possible token. The rows are ordered lexicographically by nucleotide, and the first nucleotide of the token is the most significant digit.

When a read starts, the block also computes the acceptance threshold for a downstream per-bin filter. It takes the number of tokens in the read and subtracts a penalty. The penalty is the token length times the rounded-up number of errors allowed in the read.

The bench used here is a self-checking testbench (scoreboard). A start pulse carries the read length and the error fraction. The bases then stream in, and the tokens leave with a sequence number and a last flag.

Top module: `dna_token_gen`

The control path has four states:
- **IDLE** accepts no bases.
- **FILL** accepts bases until the window holds a full token.
- **STREAM** emits one token per accepted base.
- **DRAIN** holds the final token until the consumer takes it.

Transitions:
- **start** moves from any state to FILL, or to IDLE when the length is 0.
- **fill_done** moves FILL to STREAM when the n-th base arrives and the read has more bases.
- **fill_last** moves FILL to DRAIN when the n-th base is also the last base.
- **short_end** moves FILL to IDLE when a read shorter than n ends.
- **read_end** moves STREAM to DRAIN when the last base is accepted.
- **drained** moves DRAIN to IDLE when the last token is taken.

## Requirements
- R1: After reset, `tok_valid`, `base_ready` and `thr_valid` are all low.
- R2: The token index is the sum of base_i·4^(n−1−i) over the n bases in the window. Here i = 0 is the oldest base, and the codes are A=0, C=1, G=2, T=3. So n copies of A give 0, and n copies of T give 4^n−1.
- R3: A read of length L ≥ n produces exactly L−(n−1) tokens, in read order, one for each accepted base from the n-th onward. No token appears before n bases of the current read have been accepted.
- R4: `tok_seq` numbers the tokens of a read from 0. `tok_last` is high only with the final token, and that token's `tok_seq` is L−n.
- R5: A read with 1 ≤ L < n accepts its L bases, emits no token, and then drops `base_ready`. After a read has been fully consumed, `base_ready` stays low until the next start.
- R6: While `tok_valid` is high and `tok_ready` is low, the token, its sequence number and its last flag stay unchanged, and `base_ready` is low. No base is lost.
- R7: A start pulse discards any pending token and the contents of the window. `tok_valid` is low in the cycle after the pulse.
- R8: On a start, `threshold` becomes L−(n−1)−n·ceil(L·e) and `thr_valid` goes high one cycle later. The error fraction e is `err_rate`/2^RATE_W. The ceiling is exact: the result is rounded up whenever L·`err_rate` is not a multiple of 2^RATE_W.
- R9: When the penalty reaches or exceeds the token count, or L < n−1, the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new read |
| read_len | input | LEN_W | Read length L, sampled on `start` |
| err_rate | input | RATE_W | Error fraction e as an unsigned fraction with RATE_W bits, sampled on `start` |
| base_valid | input | 1 | Base offered |
| base_code | input | 2 | Base code: A=0, C=1, G=2, T=3 |
| base_ready | output | 1 | Base will be accepted this cycle |
| tok_valid | output | 1 | Token available |
| tok_ready | input | 1 | Consumer takes the token this cycle |
| tok_index | output | 2*TOK_LEN | Presence-table row index of the token |
| tok_last | output | 1 | Final token of the read |
| tok_seq | output | LEN_W | Position of the token within the read, starting at 0 |
| thr_valid | output | 1 | Threshold computed for the current read |
| threshold | output | LEN_W | Filter acceptance threshold |

## Verification
The assertions assume the following about the inputs:
- `start` never arrives in the same cycle as an offered base.
- A read offers exactly L bases.
- `base_code` and `base_valid` do not change while a base waits for `base_ready`.

The driver keeps within these rules. It raises `start` alone for one cycle. It presents each base only from the cycle after the start. It holds each base until the handshake completes, and it stops offering bases after the L-th.

The consumer-ready signal is the only input that moves freely. It follows a pseudo-random pattern, or is held high or low, so that stalls fall on arbitrary tokens, including the last one.

// File: rtl/dna_tok_pkg.sv
package dna_tok_pkg;

    typedef enum logic [1:0] {
        NUC_A = 2'd0,
        NUC_C = 2'd1,
        NUC_G = 2'd2,
        NUC_T = 2'd3
    } nuc_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } tok_state_e;

endpackage

// File: rtl/dna_tok_window.sv
module dna_tok_window
    import dna_tok_pkg::*;
#(
    parameter int TOK_LEN = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   shift_en,
    input  logic [1:0]             base_in,
    output logic [2*TOK_LEN-1:0]   window
);

    localparam int LAST = TOK_LEN - 1;

    nuc_e stage [TOK_LEN];

    // stage[0] holds the oldest base, stage[LAST] the newest
    for (genvar g = 0; g < TOK_LEN; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= NUC_A;
            end else if (clear) begin
                stage[g] <= NUC_A;
            end else if (shift_en) begin
                if (g == LAST) begin
                    stage[g] <= nuc_e'(base_in);
                end else begin
                    stage[g] <= stage[(g == LAST) ? g : g + 1];
                end
            end
        end

        // oldest base occupies the most significant digit
        assign window[2*(LAST-g) +: 2] = stage[g];
    end

endmodule

// File: rtl/dna_tok_threshold.sv
module dna_tok_threshold #(
    parameter int TOK_LEN = 5,
    parameter int LEN_W   = 8,
    parameter int RATE_W  = 8
) (
    input  logic [LEN_W-1:0]  len_in,
    input  logic [RATE_W-1:0] rate_in,
    output logic [LEN_W-1:0]  thr_out
);

    localparam int PROD_W = LEN_W + RATE_W;
    localparam int ERR_W  = LEN_W + 1;
    localparam int PEN_W  = ERR_W + $clog2(TOK_LEN + 1);

    logic [PROD_W-1:0] prod;
    logic [ERR_W-1:0]  err_cnt;
    logic              frac_nz;
    logic [PEN_W-1:0]  penalty;
    logic [PEN_W-1:0]  span;

    always_comb begin
        prod    = PROD_W'(len_in) * PROD_W'(rate_in);
        frac_nz = |prod[RATE_W-1:0];
        // integer part of L*e, plus one when any fraction remains
        err_cnt = {1'b0, prod[PROD_W-1:RATE_W]} + ERR_W'(frac_nz);
        penalty = PEN_W'(err_cnt) * PEN_W'(TOK_LEN);
        if (len_in >= LEN_W'(TOK_LEN - 1)) begin
            span = PEN_W'(len_in - LEN_W'(TOK_LEN - 1));
        end else begin
            span = '0;
        end
        if (span > penalty) begin
            thr_out = LEN_W'(span - penalty);
        end else begin
            thr_out = '0;
        end
    end

endmodule

// File: rtl/dna_tok_ctrl.sv
module dna_tok_ctrl
    import dna_tok_pkg::*;
#(
    parameter int TOK_LEN = 5,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             base_valid,
    input  logic             tok_ready,
    output logic             base_ready,
    output logic             shift_en,
    output logic             win_clear,
    output logic             tok_valid,
    output logic             tok_last,
    output logic [LEN_W-1:0] tok_seq,
    output logic [LEN_W-1:0] len_q
);

    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(TOK_LEN);

    tok_state_e       state, state_nx;
    logic [LEN_W-1:0] base_cnt;
    logic [LEN_W-1:0] tok_cnt;
    logic [LEN_W-1:0] cnt_nx;
    logic             acc;
    logic             emit;
    logic             read_done;
    logic             taken;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // handshake and next state
    always_comb begin
        unique case (state)
            ST_IDLE:   base_ready = 1'b0;
            ST_FILL:   base_ready = !start;
            ST_STREAM: base_ready = !start && (!tok_valid || tok_ready);
            ST_DRAIN:  base_ready = 1'b0;
            default:   base_ready = 1'b0;
        endcase

        acc       = base_valid && base_ready;
        cnt_nx    = base_cnt + 1'b1;
        emit      = acc && (cnt_nx >= FULL_CNT);
        read_done = acc && (cnt_nx == len_q);
        taken     = tok_valid && tok_ready;
        shift_en  = acc;
        win_clear = start;

        state_nx = state;
        if (start) begin
            state_nx = (len_in == '0) ? ST_IDLE : ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_FILL: begin
                    if (read_done) begin
                        state_nx = emit ? ST_DRAIN : ST_IDLE;
                    end else if (emit) begin
                        state_nx = ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (read_done) begin
                        state_nx = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (taken) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // counters and output holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt  <= '0;
            tok_cnt   <= '0;
            len_q     <= '0;
            tok_valid <= 1'b0;
            tok_last  <= 1'b0;
            tok_seq   <= '0;
        end else if (start) begin
            base_cnt  <= '0;
            tok_cnt   <= '0;
            len_q     <= len_in;
            tok_valid <= 1'b0;
            tok_last  <= 1'b0;
            tok_seq   <= '0;
        end else begin
            if (acc) begin
                base_cnt <= cnt_nx;
            end
            if (emit) begin
                tok_valid <= 1'b1;
                tok_last  <= read_done;
                tok_seq   <= tok_cnt;
                tok_cnt   <= tok_cnt + 1'b1;
            end else if (taken) begin
                tok_valid <= 1'b0;
                tok_last  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dna_token_gen.sv
module dna_token_gen #(
    parameter int TOK_LEN = 5,
    parameter int LEN_W   = 8,
    parameter int RATE_W  = 8,
    localparam int IDX_W  = 2 * TOK_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  read_len,
    input  logic [RATE_W-1:0] err_rate,
    input  logic              base_valid,
    input  logic [1:0]        base_code,
    output logic              base_ready,
    output logic              tok_valid,
    input  logic              tok_ready,
    output logic [IDX_W-1:0]  tok_index,
    output logic              tok_last,
    output logic [LEN_W-1:0]  tok_seq,
    output logic              thr_valid,
    output logic [LEN_W-1:0]  threshold
);

    logic             shift_en;
    logic             win_clear;
    logic [LEN_W-1:0] read_len_q;
    logic [LEN_W-1:0] thr_comb;

    dna_tok_ctrl #(
        .TOK_LEN (TOK_LEN),
        .LEN_W   (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len_in     (read_len),
        .base_valid (base_valid),
        .tok_ready  (tok_ready),
        .base_ready (base_ready),
        .shift_en   (shift_en),
        .win_clear  (win_clear),
        .tok_valid  (tok_valid),
        .tok_last   (tok_last),
        .tok_seq    (tok_seq),
        .len_q      (read_len_q)
    );

    dna_tok_window #(
        .TOK_LEN (TOK_LEN)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (win_clear),
        .shift_en (shift_en),
        .base_in  (base_code),
        .window   (tok_index)
    );

    dna_tok_threshold #(
        .TOK_LEN (TOK_LEN),
        .LEN_W   (LEN_W),
        .RATE_W  (RATE_W)
    ) u_thr (
        .len_in  (read_len),
        .rate_in (err_rate),
        .thr_out (thr_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_valid <= 1'b0;
            threshold <= '0;
        end else if (start) begin
            thr_valid <= 1'b1;
            threshold <= thr_comb;
        end
    end

endmodule

// File: rtl/dna_token_gen_chk.sv
module dna_token_gen_chk #(
    parameter int TOK_LEN = 5,
    parameter int LEN_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 base_ready,
    input logic                 tok_valid,
    input logic                 tok_ready,
    input logic [2*TOK_LEN-1:0] tok_index,
    input logic                 tok_last,
    input logic [LEN_W-1:0]     tok_seq,
    input logic                 thr_valid,
    input logic [LEN_W-1:0]     threshold,
    input logic [LEN_W-1:0]     len_q
);

    AST_LAST_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_last |-> tok_seq == len_q - LEN_W'(TOK_LEN)); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_ready && !start |=>
            tok_valid && $stable(tok_index) && $stable(tok_seq) && $stable(tok_last)); // R6

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_ready |-> !base_ready); // R6

    AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tok_valid); // R7

    AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        thr_valid |-> threshold <= len_q); // R9

endmodule

bind dna_token_gen dna_token_gen_chk #(
    .TOK_LEN (TOK_LEN),
    .LEN_W   (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .base_ready (base_ready),
    .tok_valid  (tok_valid),
    .tok_ready  (tok_ready),
    .tok_index  (tok_index),
    .tok_last   (tok_last),
    .tok_seq    (tok_seq),
    .thr_valid  (thr_valid),
    .threshold  (threshold),
    .len_q      (read_len_q)
);

// File: tb/dna_token_gen_tb.sv
`timescale 1ns/1ps
module dna_token_gen_tb;

    localparam int N  = 5;
    localparam int LW = 8;
    localparam int RW = 8;
    localparam int TW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] read_len = '0;
    logic [RW-1:0] err_rate = '0;
    logic          base_valid = 1'b0;
    logic [1:0]    base_code = 2'd0;
    logic          base_ready;
    logic          tok_valid;
    logic          tok_ready = 1'b0;
    logic [TW-1:0] tok_index;
    logic          tok_last;
    logic [LW-1:0] tok_seq;
    logic          thr_valid;
    logic [LW-1:0] threshold;

    always #2 clk = ~clk;

    dna_token_gen #(.TOK_LEN(N), .LEN_W(LW), .RATE_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .read_len(read_len),
        .err_rate(err_rate), .base_valid(base_valid), .base_code(base_code),
        .base_ready(base_ready), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_index(tok_index), .tok_last(tok_last), .tok_seq(tok_seq),
        .thr_valid(thr_valid), .threshold(threshold)
    );

    int checks = 0;
    int fails = 0;
    int got_tokens = 0;
    int ready_mode = 1;       // 0 pseudo-random, 1 always, 2 never
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int q_idx[$];
    int q_last[$];
    int q_seq[$];
    bit stall_prev = 1'b0;
    logic [TW-1:0] idx_prev;
    logic [LW-1:0] seq_prev;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_thr(input int len, input int rate);
        int errs;
        int t;
        errs = (len * rate) / (1 << RW);
        if (errs * (1 << RW) != len * rate) errs = errs + 1;
        t = (len - (N - 1)) - N * errs;
        return (t < 0) ? 0 : t;
    endfunction

    function automatic int pick_base(input int pat, input int i, input int seed);
        case (pat)
            0: return 0;
            1: return 3;
            2: return i % 4;
            default: return ((i * 7 + seed * 13) ^ (i >> 2) ^ seed) % 4;
        endcase
    endfunction

    // consumer ready, changed just after each rising edge
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: tok_ready = lfsr[0] | lfsr[5];
            1: tok_ready = 1'b1;
            default: tok_ready = 1'b0;
        endcase
    end

    // monitor: pops the scoreboard on every handshake
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (stall_prev) begin
                check(tok_valid && tok_index == idx_prev && tok_seq == seq_prev,
                      "R6", "stalled token changed", int'(tok_index), int'(idx_prev));
            end
            stall_prev = tok_valid && !tok_ready && !start;
            idx_prev   = tok_index;
            seq_prev   = tok_seq;
            if (tok_valid && tok_ready) begin
                if (q_idx.size() == 0) begin
                    check(1'b0, "R3", "unexpected token", int'(tok_index), -1);
                end else begin
                    int ei, el, es;
                    ei = q_idx.pop_front();
                    el = q_last.pop_front();
                    es = q_seq.pop_front();
                    check(int'(tok_index) == ei, "R2", "token index", int'(tok_index), ei);
                    check(int'(tok_seq) == es, "R4", "token sequence", int'(tok_seq), es);
                    check(int'(tok_last) == el, "R4", "last flag", int'(tok_last), el);
                end
                got_tokens++;
            end
        end
    end

    task automatic pulse_start(input int len, input int rate);
        @(negedge clk);
        start = 1'b1;
        read_len = LW'(len);
        err_rate = RW'(rate);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(thr_valid && int'(threshold) == exp_thr(len, rate),
              (exp_thr(len, rate) == 0) ? "R9" : "R8", "threshold",
              int'(threshold), exp_thr(len, rate));
        @(negedge clk);
    endtask

    // drives nbase bases; entered and left at a falling edge
    task automatic drive_bases(input int len, input int nbase, input int pat, input int seed);
        int win = 0;
        int mask = (1 << TW) - 1;
        for (int i = 0; i < nbase; i++) begin
            int b = pick_base(pat, i, seed);
            win = ((win << 2) | b) & mask;
            if (i + 1 >= N) begin
                q_idx.push_back(win);
                q_last.push_back((i + 1 == len) ? 1 : 0);
                q_seq.push_back(i + 1 - N);
            end
            base_valid = 1'b1;
            base_code = 2'(b);
            #1;
            while (!base_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        base_valid = 1'b0;
    endtask

    task automatic send_read(input int len, input int rate, input int pat, input int seed);
        int expect_n;
        pulse_start(len, rate);
        got_tokens = 0;
        drive_bases(len, len, pat, seed);
        for (int k = 0; k < 400 && q_idx.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        expect_n = (len >= N) ? len - N + 1 : 0;
        check(got_tokens == expect_n, "R3", "token count", got_tokens, expect_n);
        check(q_idx.size() == 0, "R3", "tokens missing", q_idx.size(), 0);
        check(!base_ready, "R5", "ready after read", int'(base_ready), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!tok_valid && !base_ready && !thr_valid, "R1", "reset outputs",
              int'({tok_valid, base_ready, thr_valid}), 0);
        rst_n = 1'b1;

        ready_mode = 1;
        send_read(10, 0, 0, 0);        // all A -> row 0
        ready_mode = 0;
        send_read(10, 0, 1, 0);        // all T -> last row
        send_read(100, 13, 2, 0);      // ramp, ceiling rounds up
        send_read(40, 16, 3, 1);
        send_read(32, 16, 3, 2);       // exact product, no round-up
        send_read(100, 128, 3, 3);     // clamped threshold
        send_read(3, 0, 3, 4);         // shorter than a token
        send_read(5, 0, 3, 5);         // exactly one token
        ready_mode = 1;
        send_read(20, 5, 3, 6);

        // abort with a stalled token pending
        ready_mode = 2;
        pulse_start(20, 0);
        drive_bases(20, N, 3, 7);
        #1;
        check(tok_valid, "R6", "token held while stalled", int'(tok_valid), 1);
        @(negedge clk);
        start = 1'b1;
        read_len = '0;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(!tok_valid, "R7", "pending token after start", int'(tok_valid), 0);
        check(!base_ready, "R7", "ready after empty read", int'(base_ready), 0);
        q_idx.delete();
        q_last.delete();
        q_seq.delete();
        ready_mode = 0;
        send_read(12, 20, 3, 8);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule